// File: doc/BRIEF.md
# Phase/Frequency Detector with Filtered Lock Indication

The block compares two synthesizer pulse trains in the system-clock domain: a reference pulse and the pulse from the feedback divider. It measures the time between a rising edge on each input in system-clock cycles. While it waits for the lagging edge, it drives a correction pulse toward the side that is late. It drives two outputs from that pulse. The first is a pump drive level with a separate drive enable, which controls an on-chip charge pump. The second is a pair of up/down pins, which control an external pump.

A polarity input swaps the sense of every correction, to suit a tuning curve that rises or falls. A power-down input and a pump-float input both disable the pump drive. A lock filter raises a flag after three comparisons in a row that each show a small phase error. A shared output pin shows either that flag or one of the raw pulse trains.

After power-down ends, the first few correction pulses are capped at a programmable width. This keeps the restart gentle. Very short corrections are stretched to a minimum width, so the loop has no dead zone.

Top module: `pfd_lock_detect`

## Requirements
- R1: A rising edge on one input that is not matched by a rising edge on the other input in the same cycle starts a correction pulse on the next cycle. That pulse lasts k cycles, where k is the number of cycles until the other input's rising edge. A correction for the reference leading is called "up", and one for the divider leading is called "down".
- R2: A correction with k below 2 cycles is stretched to a total of 2 cycles. Edges that arrive in the same cycle give an error of 0 and produce no correction pulse.
- R3: With pol_i=1, the pump is enabled (cp_en_o=1) while exactly one of up/down is active. It drives cp_drv_o=1 for up and cp_drv_o=0 for down. With neither or both active, cp_en_o=0, meaning high impedance.
- R4: With pol_i=0, the source and sink actions of R3 are exchanged: up gives cp_drv_o=0 and down gives cp_drv_o=1.
- R5: With pol_i=1, phr_o follows up and php_low_o follows up (1 = pull low, 0 = released). With pol_i=0, both follow down instead.
- R6: zc_i=0 forces cp_en_o=0 at once, whatever the correction state.
- R7: en_i=0 forces cp_en_o=0, phr_o=0, php_low_o=0 and lock_o=1 at once. It also discards any pending or stretched correction, clears the lock history and discards comparisons.
- R8: lock_o rises on the cycle after the third consecutive comparison with an error below 2 cycles. It falls on the cycle after the first comparison with an error of 2 or more.
- R9: With fold_sel_i=0, fold_o equals lock_o. With fold_sel_i=1, fold_o equals ref_i when pol_i=1 and div_i when pol_i=0.
- R10: After en_i returns high, the first 4 comparisons are soft. During a soft comparison, the live part of the correction is shown only while its elapsed count is at most soft_cap_i cycles. The 5th comparison is shown at its full width.
- R11: cp_hi_o follows cp_hi_i, the pump current-level select.
- R12: During reset, lock_o=0 (with en_i=1) and no correction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (reference oscillator) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference pulse train |
| div_i | input | 1 | Divided oscillator pulse train |
| pol_i | input | 1 | Correction polarity select |
| fold_sel_i | input | 1 | Shared pin select: 0 lock flag, 1 raw pulse |
| cp_hi_i | input | 1 | Pump current level select |
| en_i | input | 1 | 1 operate, 0 power-down |
| zc_i | input | 1 | 0 floats the internal pump |
| soft_cap_i | input | CNT_W | Pulse width cap during soft restart |
| cp_drv_o | output | 1 | Pump drive level (1 source, 0 sink) |
| cp_en_o | output | 1 | Pump drive enable (0 = high impedance) |
| cp_hi_o | output | 1 | Pump current level |
| phr_o | output | 1 | Push-pull up/down control for an external pump |
| php_low_o | output | 1 | Open-drain control, 1 = pull low |
| lock_o | output | 1 | Filtered lock flag |
| fold_o | output | 1 | Shared lock/pulse output |

## Verification
An edge that the design samples at clock edge t shows up on the correction outputs during cycle t+1. A comparison completed at edge t moves lock_o and the soft-restart count in cycle t+1. en_i, zc_i, pol_i, fold_sel_i and cp_hi_i act in the same cycle, through gating only. The bench drives inputs just after a rising edge. Its behavioural model advances on each rising edge, using the inputs held since then. Every output is compared with the model at the following falling edge, so both the one-cycle registered results and the same-cycle gated results are sampled in the cycle they are due.

// File: rtl/pfd_ld_pkg.sv
package pfd_ld_pkg;
  typedef enum logic [1:0] {
    LEAD_NONE = 2'd0,
    LEAD_REF  = 2'd1,
    LEAD_DIV  = 2'd2
  } lead_e;
endpackage

// File: rtl/pfd_edge_cmp.sv
module pfd_edge_cmp
  import pfd_ld_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ref_i,
  input  logic             div_i,
  output lead_e            pend_o,
  output logic [CNT_W-1:0] pend_cnt_o,
  output logic             cmp_o,
  output lead_e            cmp_lead_o,
  output logic [CNT_W-1:0] cmp_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic ref_q, div_q;
  logic ref_rise, div_rise;
  lead_e pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ref_rise = ref_i & ~ref_q;
  assign div_rise = div_i & ~div_q;

  always_comb begin
    pend_d     = pend_q;
    cnt_d      = cnt_q;
    cmp_o      = 1'b0;
    cmp_lead_o = LEAD_NONE;
    cmp_err_o  = '0;
    if (!en_i) begin
      pend_d = LEAD_NONE;
      cnt_d  = '0;
    end else begin
      unique case (pend_q)
        LEAD_NONE: begin
          if (ref_rise && div_rise) begin
            cmp_o = 1'b1;
          end else if (ref_rise) begin
            pend_d = LEAD_REF;
            cnt_d  = CNT_W'(1);
          end else if (div_rise) begin
            pend_d = LEAD_DIV;
            cnt_d  = CNT_W'(1);
          end
        end
        LEAD_REF: begin
          if (div_rise) begin
            cmp_o      = 1'b1;
            cmp_lead_o = LEAD_REF;
            cmp_err_o  = cnt_q;
            pend_d     = LEAD_NONE;
            cnt_d      = '0;
          end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        LEAD_DIV: begin
          if (ref_rise) begin
            cmp_o      = 1'b1;
            cmp_lead_o = LEAD_DIV;
            cmp_err_o  = cnt_q;
            pend_d     = LEAD_NONE;
            cnt_d      = '0;
          end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          pend_d = LEAD_NONE;
          cnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      div_q  <= 1'b0;
      pend_q <= LEAD_NONE;
      cnt_q  <= '0;
    end else begin
      ref_q  <= ref_i;
      div_q  <= div_i;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pend_o     = pend_q;
  assign pend_cnt_o = cnt_q;
endmodule

// File: rtl/pfd_pulse_shaper.sv
module pfd_pulse_shaper
  import pfd_ld_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int MIN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  lead_e            pend_i,
  input  logic [CNT_W-1:0] pend_cnt_i,
  input  logic             cmp_i,
  input  lead_e            cmp_lead_i,
  input  logic [CNT_W-1:0] cmp_err_i,
  input  logic             soft_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic             up_o,
  output logic             dn_o
);
  localparam int SW = $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_W);

  logic [1:0] act;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    localparam lead_e DIR = (g == 0) ? LEAD_REF : LEAD_DIV;
    logic [SW-1:0] str_q;
    logic live;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        str_q <= '0;
      end else if (!en_i) begin
        str_q <= '0;
      end else if (cmp_i && cmp_lead_i == DIR && cmp_err_i < MIN_C) begin
        str_q <= SW'(MIN_C - cmp_err_i);
      end else if (str_q != '0) begin
        str_q <= str_q - SW'(1);
      end
    end

    // live part is trimmed to the cap while soft restart runs
    assign live   = (pend_i == DIR) && (!soft_i || pend_cnt_i <= cap_i);
    assign act[g] = live | (str_q != '0);
  end

  assign up_o = act[0];
  assign dn_o = act[1];
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
  parameter int CNT_W    = 8,
  parameter int LOCK_TOL = 2,
  parameter int LOCK_N   = 3,
  parameter int SOFT_N   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] cmp_err_i,
  output logic             lock_o,
  output logic             soft_o
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int SW = $clog2(SOFT_N + 1);

  logic [GW-1:0] good_q;
  logic [SW-1:0] soft_q;
  logic          lock_q, en_q, good_cmp;

  assign good_cmp = cmp_err_i < CNT_W'(LOCK_TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      soft_q <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        good_q <= '0;
        soft_q <= '0;
        lock_q <= 1'b0;
      end else begin
        if (!en_q) soft_q <= SW'(SOFT_N);
        else if (cmp_i && soft_q != '0) soft_q <= soft_q - SW'(1);
        if (cmp_i) begin
          if (good_cmp) begin
            if (good_q != GW'(LOCK_N)) good_q <= good_q + GW'(1);
            lock_q <= good_q >= GW'(LOCK_N - 1);
          end else begin
            good_q <= '0;
            lock_q <= 1'b0;
          end
        end
      end
    end
  end

  assign lock_o = lock_q;
  assign soft_o = soft_q != '0;
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
  import pfd_ld_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MIN_W    = 2,
  parameter int LOCK_TOL = 2,
  parameter int LOCK_N   = 3,
  parameter int SOFT_N   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             div_i,
  input  logic             pol_i,
  input  logic             fold_sel_i,
  input  logic             cp_hi_i,
  input  logic             en_i,
  input  logic             zc_i,
  input  logic [CNT_W-1:0] soft_cap_i,
  output logic             cp_drv_o,
  output logic             cp_en_o,
  output logic             cp_hi_o,
  output logic             phr_o,
  output logic             php_low_o,
  output logic             lock_o,
  output logic             fold_o
);
  lead_e            pend_w, cmp_lead_w;
  logic [CNT_W-1:0] pend_cnt_w, cmp_err_w;
  logic             cmp_w, soft_w, up_raw, dn_raw, lock_q_w;
  logic             up_w, dn_w, src_w, snk_w;

  pfd_edge_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ref_i      (ref_i),
    .div_i      (div_i),
    .pend_o     (pend_w),
    .pend_cnt_o (pend_cnt_w),
    .cmp_o      (cmp_w),
    .cmp_lead_o (cmp_lead_w),
    .cmp_err_o  (cmp_err_w)
  );

  pfd_pulse_shaper #(.CNT_W(CNT_W), .MIN_W(MIN_W)) u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .pend_i     (pend_w),
    .pend_cnt_i (pend_cnt_w),
    .cmp_i      (cmp_w),
    .cmp_lead_i (cmp_lead_w),
    .cmp_err_i  (cmp_err_w),
    .soft_i     (soft_w),
    .cap_i      (soft_cap_i),
    .up_o       (up_raw),
    .dn_o       (dn_raw)
  );

  pfd_lock_filter #(
    .CNT_W(CNT_W), .LOCK_TOL(LOCK_TOL), .LOCK_N(LOCK_N), .SOFT_N(SOFT_N)
  ) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cmp_i     (cmp_w),
    .cmp_err_i (cmp_err_w),
    .lock_o    (lock_q_w),
    .soft_o    (soft_w)
  );

  assign up_w  = up_raw & en_i;
  assign dn_w  = dn_raw & en_i;
  assign src_w = pol_i ? up_w : dn_w;
  assign snk_w = pol_i ? dn_w : up_w;

  assign cp_drv_o  = src_w;
  assign cp_en_o   = en_i & zc_i & (src_w ^ snk_w);
  assign cp_hi_o   = cp_hi_i;
  assign phr_o     = pol_i ? up_w : dn_w;
  assign php_low_o = pol_i ? up_w : dn_w;
  assign lock_o    = ~en_i | lock_q_w;
  assign fold_o    = fold_sel_i ? (pol_i ? ref_i : div_i) : lock_o;
endmodule

// File: rtl/pfd_lock_detect_chk.sv
module pfd_lock_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic zc_i,
  input logic pol_i,
  input logic cp_en_o,
  input logic cp_drv_o,
  input logic phr_o,
  input logic lock_o,
  input logic cmp_w,
  input logic soft_w
);
  // R6
  zc_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_i |-> !cp_en_o);

  // R7
  pwrdn_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (lock_o && !cp_en_o && !phr_o));

  // R5
  drive_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_en_o |-> (cp_drv_o == phr_o));

  // R2
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !soft_w && $stable(pol_i) && $rose(phr_o))
      |=> (phr_o || !en_i || !$stable(pol_i)));

  // R8
  lock_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lock_o) && en_i && $past(en_i)) |-> $past(cmp_w));
endmodule

bind pfd_lock_detect pfd_lock_detect_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .zc_i     (zc_i),
  .pol_i    (pol_i),
  .cp_en_o  (cp_en_o),
  .cp_drv_o (cp_drv_o),
  .phr_o    (phr_o),
  .lock_o   (lock_o),
  .cmp_w    (cmp_w),
  .soft_w   (soft_w)
);

// File: tb/test_pfd_lock_detect.sv
`timescale 1ns/1ps
module test_pfd_lock_detect;
  localparam int CNT_W = 8;
  localparam int MIN_W = 2;
  localparam int LOCK_TOL = 2;
  localparam int LOCK_N = 3;
  localparam int SOFT_N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_p = 0, div_p = 0, pol = 1, fsel = 0, cs = 0, en = 1, zc = 1;
  logic [CNT_W-1:0] cap = 8'd2;
  logic cp_drv, cp_en, cp_hi, phr, php_low, lock, fold;

  int n_chk = 0, n_fail = 0;
  string tag = "R12";
  bit done = 0;

  always #2.5 clk = ~clk;

  pfd_lock_detect i_pfd_lock_detect (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_p), .div_i(div_p), .pol_i(pol),
    .fold_sel_i(fsel), .cp_hi_i(cs), .en_i(en), .zc_i(zc), .soft_cap_i(cap),
    .cp_drv_o(cp_drv), .cp_en_o(cp_en), .cp_hi_o(cp_hi), .phr_o(phr),
    .php_low_o(php_low), .lock_o(lock), .fold_o(fold)
  );

  // behavioural model: 0 none, 1 reference leads, 2 divider leads
  int m_lead, m_start, m_cyc, m_ext_u, m_ext_d, m_good, m_soft;
  bit m_lock, m_pref, m_pdiv, m_pen;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lead = 0; m_start = 0; m_cyc = 0; m_ext_u = 0; m_ext_d = 0;
      m_good = 0; m_soft = 0; m_lock = 0; m_pref = 0; m_pdiv = 0; m_pen = 1;
    end else begin
      bit re, ve, hit;
      int err, who;
      re = ref_p && !m_pref;
      ve = div_p && !m_pdiv;
      hit = 0; err = 0; who = 0;
      if (m_ext_u > 0) m_ext_u--;
      if (m_ext_d > 0) m_ext_d--;
      if (!en) begin
        m_lead = 0; m_ext_u = 0; m_ext_d = 0; m_good = 0; m_lock = 0; m_soft = 0;
      end else begin
        if (m_lead == 0) begin
          if (re && ve) hit = 1;
          else if (re) begin m_lead = 1; m_start = m_cyc; end
          else if (ve) begin m_lead = 2; m_start = m_cyc; end
        end else if ((m_lead == 1 && ve) || (m_lead == 2 && re)) begin
          hit = 1; who = m_lead; err = m_cyc - m_start; m_lead = 0;
        end
        if (!m_pen) m_soft = SOFT_N;
        else if (hit && m_soft > 0) m_soft--;
        if (hit) begin
          if (err < MIN_W && who == 1) m_ext_u = MIN_W - err;
          if (err < MIN_W && who == 2) m_ext_d = MIN_W - err;
          if (err < LOCK_TOL) begin
            if (m_good < LOCK_N) m_good++;
            m_lock = (m_good >= LOCK_N);
          end else begin
            m_good = 0; m_lock = 0;
          end
        end
      end
      m_pen = en; m_pref = ref_p; m_pdiv = div_p; m_cyc++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int el;
      bit up, dn, src, snk, e_en, e_lock;
      string preq;
      el = m_cyc - m_start;
      up = en && ((m_lead == 1 && (m_soft == 0 || el <= cap)) || m_ext_u > 0);
      dn = en && ((m_lead == 2 && (m_soft == 0 || el <= cap)) || m_ext_d > 0);
      src = pol ? up : dn;
      snk = pol ? dn : up;
      e_en = en && zc && (src != snk);
      e_lock = !en || m_lock;
      preq = !en ? "R7" : (!zc ? "R6" : (pol ? "R3" : "R4"));
      chk("R5", "phr_o", phr, pol ? up : dn);
      chk("R5", "php_low_o", php_low, pol ? up : dn);
      chk(preq, "cp_en_o", cp_en, e_en);
      if (e_en) chk(preq, "cp_drv_o", cp_drv, src);
      chk(en ? "R8" : "R7", "lock_o", lock, e_lock);
      chk("R9", "fold_o", fold, fsel ? (pol ? ref_p : div_p) : e_lock);
      chk("R11", "cp_hi_o", cp_hi, cs);
    end
  end

  task automatic step(input bit r, input bit v);
    @(posedge clk); #1;
    ref_p = r; div_p = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // lead: 0 same cycle, 1 reference first, 2 divider first; k cycles apart
  task automatic pair(input int lead, input int k);
    if (lead == 0) step(1, 1);
    else begin
      if (lead == 1) step(1, 0); else step(0, 1);
      idle(k - 1);
      if (lead == 1) step(0, 1); else step(1, 0);
    end
    idle(7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset values seen at the ports
    chk("R12", "lock_o in reset", lock, 0);
    chk("R12", "cp_en_o in reset", cp_en, 0);
    chk("R12", "phr_o in reset", phr, 0);
    rst_n = 1;
    idle(3);

    tag = "R1"; pair(1, 5); pair(2, 4); pair(1, 3);
    tag = "R2"; pair(1, 1); pair(2, 1); pair(0, 0);
    tag = "R8"; pair(2, 5); pair(1, 1); pair(0, 0); pair(2, 1); pair(0, 0);
    pair(1, 4); pair(0, 0);
    tag = "R11"; cs = 1; pair(1, 2); cs = 0;
    tag = "R4"; pol = 0; pair(1, 4); pair(2, 3); pair(1, 1);
    tag = "R9"; fsel = 1; pair(1, 3); pair(2, 2); pol = 1; pair(1, 3); pair(2, 2);
    fsel = 0;
    tag = "R6"; zc = 0; pair(1, 4); pair(2, 4); zc = 1; pair(1, 2);
    tag = "R7"; pair(0, 0); pair(1, 1); pair(0, 0);
    step(1, 0); idle(2); en = 0; idle(2); step(0, 1); idle(2); pair(1, 3);
    @(posedge clk); #1; en = 1;
    tag = "R10"; cap = 8'd2; idle(3);
    for (int i = 0; i < 5; i++) pair(1, 6);
    pair(2, 6);
    cap = 8'd3; @(posedge clk); #1; en = 0; idle(2); en = 1; idle(2);
    pair(2, 5); pair(1, 1); pair(2, 6);
    idle(5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule